// File: doc/BRIEF.md
# Bayer Same-Colour Defect Pixel Corrector

This block sits in a raster pixel stream from a Bayer-pattern image sensor and removes isolated hot or dead pixels. In a Bayer mosaic the nearest pixel of the same colour in the same row lies two positions to the left and two to the right. Each pixel is compared against those two. If the pixel stands out from both of them in the same direction by more than a programmable threshold, it is treated as a defect. It is then replaced by the rounded mean of the two same-colour neighbours. All other pixels pass through unchanged.

The stream arrives one pixel per cycle when `pix_vld` is high. `line_start` marks the first pixel of each row. The block keeps a five-slot window of the current row and reports each pixel two accepted pixels after it entered. Pixels near the ends of a row lack a neighbour on one side and are never altered. A neighbour taken from another row is never used. Idle cycles can appear anywhere in the stream and have no effect on the result.

Top module: `bayer_dpc`

## Requirements
- R1: While reset is held and in the first cycle after it, `pix_out_vld` is low. After reset the window is empty, so the third accepted pixel is the first one that can produce an output.
- R2: Accepted pixels leave in order. Pixel k of the stream counted since reset (k starting at 0) is shown on `pix_out`, with `pix_out_vld` high for exactly one cycle, in the cycle after the clock edge that accepts pixel k+2. This holds across row boundaries.
- R3: A pixel is hot-corrected when, with `enable` high, it exceeds both same-colour neighbours (offsets -2 and +2 in its row) and both differences are strictly greater than `thresh`. Its output is then (left + right + 1) >> 1.
- R4: A pixel is cold-corrected when, with `enable` high, it is below both same-colour neighbours and both differences are strictly greater than `thresh`. Its output is the same rounded mean as in R3.
- R5: A pixel that lies between its neighbours, or whose difference to either neighbour is equal to or smaller than `thresh`, is output unchanged.
- R6: The first two and the last two pixels of a row, and any pixel whose -2 or +2 neighbour belongs to another row or was never received since reset, are output unchanged. A `line_start` on an accepted pixel marks a row boundary.
- R7: With `enable` low, every pixel is output unchanged, with the same latency as in R2.
- R8: The full 10-bit range is handled without wrap-around. A value of 1023 surrounded by 0 gives 0, and 0 surrounded by 1023 gives 1023. All comparisons are unsigned.
- R9: Cycles with `pix_vld` low neither shift the window nor raise `pix_out_vld`. `line_start` is ignored in such cycles. `pix_out_vld` is only ever high in the cycle after an accepted pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset; empties the window |
| enable | input | 1 | 1 = correct defects, 0 = pass through |
| thresh | input | 7 | Unsigned detection threshold (recommended value 20) |
| pix_in | input | 10 | Incoming raw pixel |
| pix_vld | input | 1 | `pix_in` is accepted at this edge |
| line_start | input | 1 | Accepted pixel is the first of a row |
| pix_out | output | 10 | Corrected pixel, meaningful while `pix_out_vld` is high |
| pix_out_vld | output | 1 | One-cycle strobe for each emitted pixel |

## Verification
The row-boundary flush and the outlier decision can act on the same output pixel. This happens when an outlier sits at a row end, or when rows are only one to three pixels long. In those cases one cycle both emits the tail of the previous row and judges a window that spans the boundary. The bench provokes this with short rows that carry strong spikes at their first and last positions, and with a long randomised run of rows 1 to 16 pixels long. Idle cycles and stray `line_start` pulses are interleaved throughout. A queue-based reference model in the bench tracks the row number of every pixel. For each emitted pixel it expects correction only when the pixels at -2 and +2 share that pixel's row. Every cycle it compares both the strobe and the value against the design.

// File: rtl/bdpc_pkg.sv
package bdpc_pkg;
   localparam int unsigned BDPC_PIX_W      = 10;
   localparam int unsigned BDPC_TH_W       = 7;
   localparam int unsigned BDPC_TH_DEFAULT = 20;
   localparam int unsigned BDPC_DIST       = 2;

   typedef enum logic [1:0] {
      JUDGE_KEEP = 2'd0,
      JUDGE_HOT  = 2'd1,
      JUDGE_COLD = 2'd2
   } judge_e;
endpackage

// File: rtl/bdpc_window.sv
module bdpc_window #(
   parameter int unsigned PIX_W = 10,
   parameter int unsigned DIST  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_vld,
   input  logic             in_sol,
   input  logic [PIX_W-1:0] in_pix,
   output logic [PIX_W-1:0] left_pix,
   output logic [PIX_W-1:0] mid_pix,
   output logic [PIX_W-1:0] right_pix,
   output logic             span_ok,
   output logic             emit
);
   localparam int unsigned WIN = 2 * DIST + 1;

   // slot 0 holds the newest pixel, slot WIN-1 the oldest
   logic [PIX_W-1:0] pix_q [WIN];
   logic [WIN-2:0]   sol_q;
   logic [WIN-1:0]   occ_q;
   logic             emit_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < int'(WIN); i++) pix_q[i] <= '0;
         sol_q  <= '0;
         occ_q  <= '0;
         emit_q <= 1'b0;
      end else begin
         emit_q <= in_vld & occ_q[DIST-1];
         if (in_vld) begin
            pix_q[0] <= in_pix;
            for (int i = 1; i < int'(WIN); i++) pix_q[i] <= pix_q[i-1];
            occ_q <= {occ_q[WIN-2:0], 1'b1};
            if (WIN > 2) sol_q <= {sol_q[WIN-3:0], in_sol};
            else         sol_q <= in_sol;
         end
      end
   end

   // a row start on any slot newer than the oldest breaks the span
   assign span_ok   = occ_q[WIN-1] & ~(|sol_q);
   assign left_pix  = pix_q[WIN-1];
   assign mid_pix   = pix_q[DIST];
   assign right_pix = pix_q[0];
   assign emit      = emit_q;
endmodule

// File: rtl/bdpc_judge.sv
module bdpc_judge
   import bdpc_pkg::*;
#(
   parameter int unsigned PIX_W = 10,
   parameter int unsigned TH_W  = 7
) (
   input  logic [PIX_W-1:0] left_pix,
   input  logic [PIX_W-1:0] mid_pix,
   input  logic [PIX_W-1:0] right_pix,
   input  logic [TH_W-1:0]  thresh,
   output judge_e           verdict
);
   logic [PIX_W-1:0] th_ext;
   logic [PIX_W-1:0] up_l, up_r, dn_l, dn_r;
   logic             above, below;

   assign th_ext = PIX_W'(thresh);
   // differences are only used when their sign is known positive
   assign up_l = mid_pix - left_pix;
   assign up_r = mid_pix - right_pix;
   assign dn_l = left_pix - mid_pix;
   assign dn_r = right_pix - mid_pix;

   assign above = (mid_pix > left_pix) && (mid_pix > right_pix) &&
                  (up_l > th_ext) && (up_r > th_ext);
   assign below = (mid_pix < left_pix) && (mid_pix < right_pix) &&
                  (dn_l > th_ext) && (dn_r > th_ext);

   always_comb begin
      if (above)      verdict = JUDGE_HOT;
      else if (below) verdict = JUDGE_COLD;
      else            verdict = JUDGE_KEEP;
   end
endmodule

// File: rtl/bdpc_blend.sv
module bdpc_blend #(
   parameter int unsigned PIX_W    = 10,
   parameter bit          ROUND_UP = 1'b1
) (
   input  logic [PIX_W-1:0] a_pix,
   input  logic [PIX_W-1:0] b_pix,
   output logic [PIX_W-1:0] mean_pix
);
   logic [PIX_W:0] sum;

   generate
      if (ROUND_UP) begin : g_round
         assign sum = {1'b0, a_pix} + {1'b0, b_pix} + (PIX_W+1)'(1);
      end else begin : g_trunc
         assign sum = {1'b0, a_pix} + {1'b0, b_pix};
      end
   endgenerate

   assign mean_pix = PIX_W'(sum >> 1);
endmodule

// File: rtl/bayer_dpc.sv
module bayer_dpc
   import bdpc_pkg::*;
#(
   parameter int unsigned PIX_W    = BDPC_PIX_W,
   parameter int unsigned TH_W     = BDPC_TH_W,
   parameter int unsigned DIST     = BDPC_DIST,
   parameter bit          ROUND_UP = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic [TH_W-1:0]  thresh,
   input  logic [PIX_W-1:0] pix_in,
   input  logic             pix_vld,
   input  logic             line_start,
   output logic [PIX_W-1:0] pix_out,
   output logic             pix_out_vld
);
   generate
      if (TH_W > PIX_W) begin : g_bad_th
         $error("bayer_dpc: threshold wider than pixel");
      end
      if (DIST < 1) begin : g_bad_dist
         $error("bayer_dpc: same-colour distance must be at least 1");
      end
      if (PIX_W < 2) begin : g_bad_pix
         $error("bayer_dpc: pixel width too small");
      end
   endgenerate

   logic [PIX_W-1:0] w_left, w_mid, w_right, w_mean;
   logic             w_span, w_emit;
   judge_e           w_verdict;

   bdpc_window #(.PIX_W(PIX_W), .DIST(DIST)) u_window (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_vld    (pix_vld),
      .in_sol    (line_start),
      .in_pix    (pix_in),
      .left_pix  (w_left),
      .mid_pix   (w_mid),
      .right_pix (w_right),
      .span_ok   (w_span),
      .emit      (w_emit)
   );

   bdpc_judge #(.PIX_W(PIX_W), .TH_W(TH_W)) u_judge (
      .left_pix  (w_left),
      .mid_pix   (w_mid),
      .right_pix (w_right),
      .thresh    (thresh),
      .verdict   (w_verdict)
   );

   bdpc_blend #(.PIX_W(PIX_W), .ROUND_UP(ROUND_UP)) u_blend (
      .a_pix    (w_left),
      .b_pix    (w_right),
      .mean_pix (w_mean)
   );

   assign pix_out     = (enable && w_span && (w_verdict != JUDGE_KEEP)) ? w_mean : w_mid;
   assign pix_out_vld = w_emit;
endmodule

// File: rtl/bayer_dpc_chk.sv
module bayer_dpc_chk #(
   parameter int unsigned PIX_W    = 10,
   parameter int unsigned DIST     = 2,
   parameter bit          ROUND_UP = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             enable,
   input logic [PIX_W-1:0] pix_in,
   input logic             pix_vld,
   input logic             line_start,
   input logic [PIX_W-1:0] pix_out,
   input logic             pix_out_vld
);
   localparam int unsigned WIN = 2 * DIST + 1;

   logic [PIX_W-1:0] h [WIN];
   logic [WIN-1:0]   hs;
   logic [WIN-1:0]   hocc;
   logic [PIX_W:0]   pair_sum;
   logic [PIX_W-1:0] pair_mean;
   logic             boundary;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < int'(WIN); i++) h[i] <= '0;
         hs   <= '0;
         hocc <= '0;
      end else if (pix_vld) begin
         h[0] <= pix_in;
         for (int i = 1; i < int'(WIN); i++) h[i] <= h[i-1];
         hs   <= {hs[WIN-2:0], line_start};
         hocc <= {hocc[WIN-2:0], 1'b1};
      end
   end

   assign pair_sum  = {1'b0, h[0]} + {1'b0, h[WIN-1]} + (PIX_W+1)'(ROUND_UP);
   assign pair_mean = PIX_W'(pair_sum >> 1);
   assign boundary  = !hocc[WIN-1] || (|hs[WIN-2:0]);

   // R9: a strobe only follows an accepted pixel
   a_r9_strobe_follows_input: assert property (@(posedge clk) disable iff (!rst_n)
      pix_out_vld |-> $past(pix_vld));

   // R7: bypass leaves the delayed pixel untouched
   a_r7_bypass: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_out_vld && !enable) |-> (pix_out == h[DIST]));

   // R3: output is either the original or the neighbour mean
   a_r3_mean_or_orig: assert property (@(posedge clk) disable iff (!rst_n)
      pix_out_vld |-> ((pix_out == h[DIST]) || (pix_out == pair_mean)));

   // R5: replacement only for a one-sided outlier
   a_r5_same_direction: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_out_vld && (pix_out != h[DIST])) |->
         (((h[DIST] > h[0]) && (h[DIST] > h[WIN-1])) ||
          ((h[DIST] < h[0]) && (h[DIST] < h[WIN-1]))));

   // R6: no correction across a row boundary or into an unfilled slot
   a_r6_edge_pass: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_out_vld && boundary) |-> (pix_out == h[DIST]));
endmodule

bind bayer_dpc bayer_dpc_chk #(.PIX_W(PIX_W), .DIST(DIST), .ROUND_UP(ROUND_UP)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .enable      (enable),
   .pix_in      (pix_in),
   .pix_vld     (pix_vld),
   .line_start  (line_start),
   .pix_out     (pix_out),
   .pix_out_vld (pix_out_vld)
);

// File: tb/tb_bayer_dpc.sv
module tb_bayer_dpc;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       enable = 1'b1;
   logic [6:0] thresh = 7'd20;
   logic [9:0] pix_in = '0;
   logic       pix_vld = 1'b0;
   logic       line_start = 1'b0;
   logic [9:0] pix_out;
   logic       pix_out_vld;

   always #10 clk = ~clk;

   bayer_dpc dut (
      .clk(clk), .rst_n(rst_n), .enable(enable), .thresh(thresh),
      .pix_in(pix_in), .pix_vld(pix_vld), .line_start(line_start),
      .pix_out(pix_out), .pix_out_vld(pix_out_vld)
   );

   int    n_tests = 0;
   int    n_fail  = 0;
   bit    finished = 1'b0;
   string req = "R1";

   int  pv[$];
   int  lid[$];
   int  cur_line = -1;
   bit  exp_vld = 1'b0;
   int  exp_val = 0;
   bit  en_next = 1'b1;
   int  th_next = 20;

   function automatic int model(int j);
      int l, c, r;
      c = pv[j];
      if (!en_next) return c;
      if (j < 2) return c;
      if (lid[j-2] != lid[j+2]) return c;
      l = pv[j-2];
      r = pv[j+2];
      if ((c > l && c > r && c - l > th_next && c - r > th_next) ||
          (c < l && c < r && l - c > th_next && r - c > th_next))
         return (l + r + 1) / 2;
      return c;
   endfunction

   task automatic check_out();
      n_tests++;
      if (pix_out_vld !== exp_vld) begin
         n_fail++;
         $display("FAIL %s: pix_out_vld=%0b expected %0b", req, pix_out_vld, exp_vld);
      end else if (exp_vld && (int'(pix_out) != exp_val)) begin
         n_fail++;
         $display("FAIL %s: pix_out=%0d expected %0d", req, pix_out, exp_val);
      end
   endtask

   task automatic step(input bit v, input bit s, input int val);
      @(negedge clk);
      check_out();
      enable     = en_next;
      thresh     = 7'(th_next);
      pix_vld    = v;
      line_start = s;
      pix_in     = 10'(val);
      exp_vld    = 1'b0;
      if (v) begin
         if (s) cur_line++;
         pv.push_back(val);
         lid.push_back(cur_line);
         if (pv.size() >= 3) begin
            exp_vld = 1'b1;
            exp_val = model(pv.size() - 3);
         end
      end
   endtask

   task automatic send_line(input int vals[]);
      foreach (vals[i]) step(1'b1, i == 0, vals[i]);
   endtask

   initial begin
      int rl, base, v;
      repeat (3) @(negedge clk);
      req = "R1";
      n_tests++;
      if (pix_out_vld !== 1'b0) begin
         n_fail++;
         $display("FAIL R1: pix_out_vld=%0b expected 0 in reset", pix_out_vld);
      end
      rst_n = 1'b1;
      step(1'b0, 1'b0, 0);
      step(1'b0, 1'b0, 0);

      req = "R2";  // flat row, in-order delivery
      send_line('{100, 100, 100, 100, 100, 100, 100, 100, 100, 100, 100, 100});
      req = "R3";  // hot spike, asymmetric neighbours
      send_line('{80, 90, 80, 90, 300, 90, 120, 90, 80, 90});
      req = "R4";  // cold dip
      send_line('{500, 500, 500, 500, 100, 500, 500, 500});
      req = "R5";  // difference equal to threshold keeps, 21 corrects
      send_line('{100, 0, 100, 0, 120, 0, 100, 0, 121, 0, 100, 0, 100});
      req = "R5";  // monotone pixel between its neighbours
      send_line('{100, 0, 300, 0, 500, 0, 700, 0});
      req = "R6";  // spikes in the first two and last two slots
      send_line('{900, 900, 100, 100, 100, 100, 900, 900});
      req = "R6";  // tiny rows
      send_line('{900});
      send_line('{0, 900, 0});
      send_line('{10, 10, 900, 10, 10});
      req = "R7";
      en_next = 1'b0;
      send_line('{100, 100, 100, 100, 900, 100, 100, 100});
      en_next = 1'b1;
      req = "R8";
      send_line('{0, 0, 0, 0, 1023, 0, 0, 0, 0});
      send_line('{1023, 1023, 1023, 1023, 0, 1023, 1023, 1023});
      send_line('{1023, 5, 1021, 5, 10, 5, 1023, 5});
      req = "R3";  // threshold extremes
      th_next = 0;
      send_line('{50, 50, 51, 50, 50, 50, 49, 50, 50});
      th_next = 127;
      send_line('{0, 0, 127, 0, 0, 0, 128, 0, 0});
      th_next = 20;
      req = "R9";  // gaps and stray line_start while idle
      step(1'b1, 1'b1, 200);
      step(1'b0, 1'b1, 0);
      step(1'b1, 1'b0, 200);
      step(1'b0, 1'b0, 0);
      step(1'b0, 1'b1, 0);
      step(1'b1, 1'b0, 600);
      step(1'b1, 1'b0, 200);
      step(1'b0, 1'b0, 0);
      step(1'b1, 1'b0, 200);
      step(1'b1, 1'b0, 200);

      req = "R2";  // randomised rows
      for (int ln = 0; ln < 400; ln++) begin
         rl      = $urandom_range(1, 16);
         en_next = ($urandom_range(0, 7) != 0);
         th_next = $urandom_range(0, 127);
         base    = $urandom_range(0, 1023);
         for (int p = 0; p < rl; p++) begin
            v = base + $urandom_range(0, 40) - 20;
            if ($urandom_range(0, 5) == 0) v = $urandom_range(0, 1023);
            if (v < 0) v = 0;
            if (v > 1023) v = 1023;
            if ($urandom_range(0, 4) == 0) step(1'b0, $urandom_range(0, 1) == 1, 0);
            step(1'b1, p == 0, v);
         end
      end
      step(1'b0, 1'b0, 0);
      step(1'b0, 1'b0, 0);
      if (!finished) begin
         finished = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: run did not end, expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule